// File: doc/BRIEF.md
# Seven-Level Inverted-Sine Multicarrier PWM Generator

This block drives the gates of a three-phase inverter in which every phase is built from two series H-bridges fed by unequal DC sources, the second source twice the first. Each phase can then be set to one of seven voltages: zero, the small bridge alone, the large bridge alone, or both together, each of the non-zero ones in either polarity. A single reference phase accumulator, with fixed offsets of one third and two thirds of a turn, sets the position of the three sinusoidal references. A second accumulator sets the position of a carrier whose shape is one minus the absolute value of a sine, an inverted sine arc.

For each phase the reference magnitude, scaled by a modulation index, is compared with three copies of the carrier, each placed in its own band and the bands stacked one above the other. The number of carriers the reference lies above gives a level from 0 to 3. The sign of the reference is kept apart from this count. The signed level is decoded into a target state for each of the four half-bridge legs of the phase. Each leg then passes through a dead-time stage that drives its complementary upper and lower gates.

Both tuning words are inputs, so the reference (typically 50 Hz) and the carrier (typically close to 4 kHz) are set by the system. While enable is low every gate is off and both accumulators sit at zero. They start from zero on the first enabled edge.

Top module: `ispwm7_gen`

## Requirements
- R1: While reset is asserted or `en_i` is low, all 24 gate outputs are 0 and stay 0 whatever the tuning words and modulation index are.
- R2: Both accumulators hold zero while disabled. After n enabled clock edges they hold n times their tuning word, modulo 2^PH_W, and the tuning word in force on each edge is the one that is added.
- R3: A phase angle p gives a reference magnitude T(a) and sign p[PH_W-1], which is negative when set. The quadrant is q = p[PH_W-1:PH_W-2], the index is i = p[PH_W-3 -: TBL_AW], and a = i when q[0] = 0, otherwise a = 2^TBL_AW-1-i. T(k) = floor(F·16u / (5D² − 4u)), where u = k(D−k), D = 2^(TBL_AW+1) and F = 2^AMP_W − 1. The compared value is floor(3·T(a)·mod_idx_i / 2^MI_W).
- R4: The three carriers are j·F + F − T(a_c) for j = 0, 1, 2. Here a_c is derived from the carrier accumulator in the same way as in R3, and all three bands and all three phases share that one carrier value.
- R5: The magnitude level of a phase is the number of carriers that its compared reference value strictly exceeds (0 to 3).
- R6: Phase A uses the reference accumulator. Phases B and C add 1·K and 2·K to it, with K = floor(2^PH_W / 3).
- R7: Magnitude 0 leaves both bridges at zero. Magnitude 1 makes the small bridge active and the large bridge zero. Magnitude 2 makes the large bridge active and the small bridge zero. Magnitude 3 makes both bridges active. Every active bridge takes the polarity of the reference sign.
- R8: The gate byte of phase p sits at gate_o[8p+7:8p]. Bits 0/1 are the upper/lower gates of the small bridge's left leg, bits 2/3 those of its right leg, and bits 4..7 are the same four for the large bridge. Positive active means left upper and right lower on. Negative active means left lower and right upper on. Zero means both lower gates on.
- R9: The upper and lower gates of one leg are never both 1.
- R10: When a leg's target changes, both of its gates are 0 for max(dead_i, 1) clock cycles, after which the gate for the new target turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low forces gates off and clears the accumulators |
| mod_idx_i | input | MI_W | Modulation index, full scale 2^MI_W |
| ref_ftw_i | input | PH_W | Reference tuning word added per enabled cycle |
| car_ftw_i | input | PH_W | Carrier tuning word added per enabled cycle |
| dead_i | input | DT_W | Dead time in clock cycles |
| gate_o | output | 24 | Gate drives, eight per phase as in R8 |

## Verification
The bench builds the block with a 16-bit accumulator, a 64-entry quarter table, 10-bit amplitudes, an 8-bit modulation index and a 4-bit dead time. With a 16-bit accumulator a single enabled edge with a chosen tuning word moves both phases to any angle, and a zero tuning word then freezes them there. This brings every quadrant, every level and both polarities within reach in a few cycles, and each frozen point is compared with a model computed from the formulas above. Dead-time settings of 0 and 3 exercise the clamped minimum and a counted interval on a real level change.

// File: rtl/ispwm7_pkg.sv
package ispwm7_pkg;

    // Signed level of one phase: magnitude 0..3 plus polarity
    typedef struct packed {
        logic       neg;
        logic [1:0] mag;
    } lvl_t;

    // Quarter-wave sine sample k of a table with 2^aw entries, scaled to 2^amp_w-1,
    // from a rational approximation that is exact at 0 and at a quarter turn.
    function automatic longint unsigned qsine_entry(input int unsigned k,
                                                    input int unsigned aw,
                                                    input int unsigned amp_w);
        longint unsigned d;
        longint unsigned u;
        longint unsigned fs;
        d  = longint'(2) << aw;
        u  = longint'(k) * (d - longint'(k));
        fs = (longint'(1) << amp_w) - 1;
        return (fs * 16 * u) / (5 * d * d - 4 * u);
    endfunction

endpackage

// File: rtl/ispwm7_sine_mag.sv
module ispwm7_sine_mag #(
    parameter int TBL_AW = 6,
    parameter int AMP_W  = 10
) (
    input  logic [TBL_AW+1:0] phase_i,
    output logic [AMP_W-1:0]  mag_o,
    output logic              neg_o
);
    localparam int N = 1 << TBL_AW;

    logic [AMP_W-1:0]  tbl [N];
    logic [1:0]        quad;
    logic [TBL_AW-1:0] idx;
    logic [TBL_AW-1:0] addr;

    for (genvar g = 0; g < N; g++) begin : g_tbl
        assign tbl[g] = AMP_W'(ispwm7_pkg::qsine_entry(g, TBL_AW, AMP_W));
    end

    assign quad  = phase_i[TBL_AW+1 -: 2];
    assign idx   = phase_i[TBL_AW-1:0];
    assign addr  = quad[0] ? ~idx : idx;
    assign mag_o = tbl[addr];
    assign neg_o = quad[1];

endmodule

// File: rtl/ispwm7_level.sv
module ispwm7_level #(
    parameter int AMP_W = 10,
    parameter int MI_W  = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  en_i,
    input  logic [AMP_W-1:0]      ref_mag_i,
    input  logic                  ref_neg_i,
    input  logic [AMP_W-1:0]      car_mag_i,
    input  logic [MI_W-1:0]       mi_i,
    output ispwm7_pkg::lvl_t      lvl_o
);
    localparam int NCAR = 3;
    localparam int RW   = AMP_W + MI_W + 2;
    localparam logic [RW-1:0] FS = RW'((1 << AMP_W) - 1);

    typedef struct packed {
        ispwm7_pkg::lvl_t lvl;
    } state_t;

    state_t state_d, state_q;

    logic [RW-1:0]   prod;
    logic [RW-1:0]   ref_s;
    logic [RW-1:0]   inv_arc;
    logic [RW-1:0]   carrier [NCAR];
    logic [NCAR-1:0] hit;
    logic [1:0]      count;

    assign prod    = RW'(ref_mag_i) * RW'(mi_i) * RW'(3);
    assign ref_s   = prod >> MI_W;
    assign inv_arc = FS - RW'(car_mag_i);

    for (genvar j = 0; j < NCAR; j++) begin : g_car
        assign carrier[j] = RW'(j) * FS + inv_arc;
        assign hit[j]     = ref_s > carrier[j];
    end

    always_comb begin
        count = '0;
        for (int j = 0; j < NCAR; j++) begin
            count = count + 2'(hit[j]);
        end
        state_d = state_q;
        if (en_i) begin
            state_d.lvl.mag = count;
            state_d.lvl.neg = ref_neg_i;
        end else begin
            state_d.lvl = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign lvl_o = state_q.lvl;

    // R5
    band_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hit[2] |-> (hit[1] && hit[0]));

    // R1
    level_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (lvl_o.mag == 2'd0));

endmodule

// File: rtl/ispwm7_deadband.sv
module ispwm7_deadband #(
    parameter int DT_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            en_i,
    input  logic [DT_W-1:0] dt_i,
    input  logic            want_up_i,
    output logic            up_o,
    output logic            lo_o
);
    typedef struct packed {
        logic            up;
        logic            lo;
        logic            tgt;
        logic [DT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = '0;
        end else if (want_up_i != state_q.tgt) begin
            state_d.up  = 1'b0;
            state_d.lo  = 1'b0;
            state_d.tgt = want_up_i;
            state_d.cnt = (dt_i == '0) ? '0 : dt_i - 1'b1;
        end else if (state_q.cnt != '0) begin
            state_d.up  = 1'b0;
            state_d.lo  = 1'b0;
            state_d.cnt = state_q.cnt - 1'b1;
        end else begin
            state_d.up  = state_q.tgt;
            state_d.lo  = !state_q.tgt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    assign up_o = state_q.up;
    assign lo_o = state_q.lo;

    // R9
    no_shoot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(up_o && lo_o));

    // R10
    up_after_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(up_o) |-> $past(!lo_o));

    // R10
    lo_after_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lo_o) |-> $past(!up_o));

    // R10
    gap_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && (want_up_i != state_q.tgt)) |=> (!up_o && !lo_o));

endmodule

// File: rtl/ispwm7_gen.sv
module ispwm7_gen #(
    parameter int PH_W   = 32,
    parameter int TBL_AW = 6,
    parameter int AMP_W  = 10,
    parameter int MI_W   = 8,
    parameter int DT_W   = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic [MI_W-1:0]   mod_idx_i,
    input  logic [PH_W-1:0]   ref_ftw_i,
    input  logic [PH_W-1:0]   car_ftw_i,
    input  logic [DT_W-1:0]   dead_i,
    output logic [23:0]       gate_o
);
    localparam int NPH   = 3;
    localparam int NLEG  = 4;
    localparam int SLICE = TBL_AW + 2;
    localparam logic [PH_W:0]   FULL = {1'b1, {PH_W{1'b0}}};
    localparam logic [PH_W-1:0] OFS  = PH_W'(FULL / 3);

    typedef struct packed {
        logic [PH_W-1:0] ref_acc;
        logic [PH_W-1:0] car_acc;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (en_i) begin
            state_d.ref_acc = state_q.ref_acc + ref_ftw_i;
            state_d.car_acc = state_q.car_acc + car_ftw_i;
        end else begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    logic [AMP_W-1:0] car_mag;
    logic             car_neg_unused;

    ispwm7_sine_mag #(.TBL_AW(TBL_AW), .AMP_W(AMP_W)) u_car_arc (
        .phase_i (state_q.car_acc[PH_W-1 -: SLICE]),
        .mag_o   (car_mag),
        .neg_o   (car_neg_unused)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        logic [PH_W-1:0]   ph;
        logic [AMP_W-1:0]  ref_mag;
        logic              ref_neg;
        ispwm7_pkg::lvl_t  lvl;
        logic [NLEG-1:0]   want_up;
        logic              act_small;
        logic              act_large;

        assign ph = state_q.ref_acc + PH_W'(p) * OFS;

        ispwm7_sine_mag #(.TBL_AW(TBL_AW), .AMP_W(AMP_W)) u_ref (
            .phase_i (ph[PH_W-1 -: SLICE]),
            .mag_o   (ref_mag),
            .neg_o   (ref_neg)
        );

        ispwm7_level #(.AMP_W(AMP_W), .MI_W(MI_W)) u_lvl (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .en_i      (en_i),
            .ref_mag_i (ref_mag),
            .ref_neg_i (ref_neg),
            .car_mag_i (car_mag),
            .mi_i      (mod_idx_i),
            .lvl_o     (lvl)
        );

        // small bridge carries level bit 0, large bridge level bit 1
        always_comb begin
            act_small  = lvl.mag[0];
            act_large  = lvl.mag[1];
            want_up[0] = act_small && !lvl.neg;
            want_up[1] = act_small &&  lvl.neg;
            want_up[2] = act_large && !lvl.neg;
            want_up[3] = act_large &&  lvl.neg;
        end

        for (genvar l = 0; l < NLEG; l++) begin : g_leg
            ispwm7_deadband #(.DT_W(DT_W)) u_db (
                .clk_i     (clk_i),
                .rst_i     (rst_i),
                .en_i      (en_i),
                .dt_i      (dead_i),
                .want_up_i (want_up[l]),
                .up_o      (gate_o[8*p + 2*l]),
                .lo_o      (gate_o[8*p + 2*l + 1])
            );
        end

        // R7
        zero_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (lvl.mag == 2'd0) |-> (want_up == '0));
    end

    // R1
    gates_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (gate_o == '0));

    // R2
    acc_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (state_q.ref_acc == '0 && state_q.car_acc == '0));

endmodule

// File: tb/ispwm7_gen_tb.sv
`timescale 1ns/1ps
module ispwm7_gen_tb;
    localparam int PH_W = 16, TBL_AW = 6, AMP_W = 10, MI_W = 8, DT_W = 4;
    localparam int OFS  = 65536 / 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic [MI_W-1:0] mi  = '0;
    logic [PH_W-1:0] rftw = '0;
    logic [PH_W-1:0] cftw = '0;
    logic [DT_W-1:0] dt  = 4'd2;
    logic [23:0]     gate;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ispwm7_gen #(.PH_W(PH_W), .TBL_AW(TBL_AW), .AMP_W(AMP_W), .MI_W(MI_W), .DT_W(DT_W)) u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .mod_idx_i(mi),
        .ref_ftw_i(rftw), .car_ftw_i(cftw), .dead_i(dt), .gate_o(gate)
    );

    function automatic int tbl(int k);
        longint d, u;
        d = 128;
        u = longint'(k) * (d - k);
        return int'((longint'(1023) * 16 * u) / (5 * d * d - 4 * u));
    endfunction

    function automatic int smag(logic [15:0] ph);
        int idx;
        idx = int'(ph[13:8]);
        return ph[14] ? tbl(63 - idx) : tbl(idx);
    endfunction

    // returns {neg, mag[1:0]}
    function automatic logic [2:0] model_lvl(logic [15:0] ph, logic [15:0] cph, int m);
        int r, inv, cnt;
        r   = (smag(ph) * m * 3) >> 8;
        inv = 1023 - smag(cph);
        cnt = 0;
        for (int j = 0; j < 3; j++) if (r > j * 1023 + inv) cnt++;
        return {ph[15], 2'(cnt)};
    endfunction

    function automatic logic [7:0] model_byte(logic [2:0] lv);
        logic [3:0] up;
        logic [7:0] b;
        up[0] = lv[0] && !lv[2];
        up[1] = lv[0] &&  lv[2];
        up[2] = lv[1] && !lv[2];
        up[3] = lv[1] &&  lv[2];
        for (int l = 0; l < 4; l++) begin
            b[2*l]   = up[l];
            b[2*l+1] = !up[l];
        end
        return b;
    endfunction

    function automatic logic [23:0] model_gates(logic [15:0] ph, logic [15:0] cph, int m);
        logic [23:0] g;
        for (int p = 0; p < 3; p++)
            g[8*p +: 8] = model_byte(model_lvl(16'(ph + p * OFS), cph, m));
        return g;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one enabled edge with the given words, then frozen
    task automatic park(input logic [15:0] ph, input logic [15:0] cph, input int m);
        @(negedge clk);
        en = 1'b0; rftw = '0; cftw = '0; mi = MI_W'(m);
        repeat (2) @(negedge clk);
        rftw = ph; cftw = cph; en = 1'b1;
        @(negedge clk);
        rftw = '0; cftw = '0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(gate == '0, "R1 gates in reset", 32'(gate), 0);
        rst = 1'b0;
        rftw = 16'h1111; cftw = 16'h2222; mi = 8'd200;
        repeat (5) @(negedge clk);
        check(gate == '0, "R1 gates while disabled", 32'(gate), 0);
    endtask

    task automatic t_disable();
        park(16'h4000, 16'h0000, 255);
        rftw = 16'h0101; cftw = 16'h0303;
        en = 1'b0;
        repeat (2) @(negedge clk);
        check(gate == '0, "R1 gates off after enable falls", 32'(gate), 0);
        rftw = '0; cftw = '0;
    endtask

    task automatic t_zero_index();
        park(16'h5a5a, 16'h1234, 0);
        check(gate == 24'haaaaaa, "R3 zero index keeps lower gates", 32'(gate), 32'h00aaaaaa);
    endtask

    task automatic t_offsets();
        logic [23:0] e;
        park(16'h0000, 16'h0000, 255);
        e = model_gates(16'h0000, 16'h0000, 255);
        check(gate == e, "R6 R7 R8 phases at 0/120/240", 32'(gate), 32'(e));
        check(gate[15:8] == 8'b1001_1010, "R8 phase B large bridge positive", 32'(gate[15:8]), 32'h9a);
        check(gate[23:16] == 8'b0110_1010, "R8 phase C large bridge negative", 32'(gate[23:16]), 32'h6a);
    endtask

    task automatic t_carrier_shape();
        logic [23:0] e;
        park(16'h4000, 16'h0000, 255);
        e = model_gates(16'h4000, 16'h0000, 255);
        check(gate[7:0] == 8'b1001_1010, "R4 R5 crest vs carrier top gives level 2", 32'(gate[7:0]), 32'h9a);
        park(16'h4000, 16'h3f00, 255);
        e = model_gates(16'h4000, 16'h3f00, 255);
        check(gate[7:0] == 8'b1001_1001, "R4 R5 crest vs carrier trough gives level 3", 32'(gate[7:0]), 32'h99);
        check(gate == e, "R4 full gate word at carrier trough", 32'(gate), 32'(e));
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 12; k++) begin
            logic [15:0] ph, cph;
            int          m;
            logic [23:0] e;
            ph  = 16'(k * 5461 + 300);
            cph = 16'(k * 7000);
            m   = 64 + k * 16;
            park(ph, cph, m);
            e = model_gates(ph, cph, m);
            check(gate == e, "R3 R5 R7 sweep point", 32'(gate), 32'(e));
        end
    endtask

    task automatic t_accumulate();
        logic [23:0] e;
        @(negedge clk);
        en = 1'b0; mi = 8'd230;
        repeat (2) @(negedge clk);
        rftw = 16'h0d05; cftw = 16'h0b00; en = 1'b1;
        repeat (5) @(negedge clk);
        rftw = '0; cftw = '0;
        repeat (20) @(negedge clk);
        e = model_gates(16'(5 * 16'h0d05), 16'(5 * 16'h0b00), 230);
        check(gate == e, "R2 five enabled edges accumulate", 32'(gate), 32'(e));
    endtask

    task automatic t_dead(input int d);
        int  low;
        bit  overlap;
        dt = DT_W'(d);
        park(16'h0000, 16'h0000, 255);
        rftw = 16'h4000;
        @(negedge clk);
        rftw = '0;
        low = 0;
        overlap = 0;
        for (int c = 0; c < 40; c++) begin
            if (gate[4]) break;
            if (!gate[4] && !gate[5]) low++;
            @(negedge clk);
        end
        for (int c = 0; c < 10; c++) begin
            if (gate[4] && gate[5]) overlap = 1;
            @(negedge clk);
        end
        check(low == ((d == 0) ? 1 : d), "R10 dead interval length", 32'(low), 32'((d == 0) ? 1 : d));
        check(!overlap && gate[5:4] == 2'b01, "R9 R10 new gate on after gap", 32'(gate[5:4]), 32'h1);
    endtask

    initial begin
        t_reset();
        t_zero_index();
        t_offsets();
        t_carrier_shape();
        t_sweep();
        t_accumulate();
        t_dead(3);
        t_dead(0);
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule